// File: doc/BRIEF.md
# Variable-Length Configuration Frame Parser

This block sits behind a time-command decoder. Once that decoder has recognised a configuration/status command, it gives this block a one-cycle frame-start pulse. It then delivers the frame as single bits, each qualified by a bit-valid strobe. The parser reads a direction bit and a 4-bit subcommand index, and looks up how many data bits that index carries. It collects the data field and then compares the trailing 8-bit checksum with its own running sum.

A write frame always ends in an acknowledge pulse. The acknowledge bit is 1 when the checksum matches and 0 when it does not. A matching write to a writable index also produces a one-cycle register-write strobe, which carries the index, the field length and the data right-aligned on a wide bus. A read frame ends after its header. The parser only flags it, with the index, for a separate responder.

While a frame is in progress, extra command pulses and stray bits do not restart reception. A programmable idle timeout drops a stalled frame.

Top module: `cfg_frame_parser`

## Requirements
- R1: After reset the parser waits for a frame start, and `ackValid`, `wrStrobe` and `readReq` are all low.
- R2: The first frame bit is the direction bit (1 = write). The next four bits are the index, MSB first. When the direction bit is 0, `readReq` pulses for one cycle after the fifth bit, with `readIndex` set to the index, and no acknowledge follows.
- R3: The data field is sent MSB first. Its length in bits depends on the index: 0:8, 1:24, 2:8, 3:18, 4:8, 5:124, 6:124, 7:42, 8:56, 9:160, 10:46, 11:8, 12:1024, 13:352, 14:0, 15:16.
- R4: The expected checksum is computed over the direction bit, the index bits and the data bits. These are grouped into bytes from the first bit, and the last partial byte is filled with zeros at its low end. The bytes are added with end-around carry, and the expected checksum is the bitwise inverse of that sum. The 8 checksum bits are sent MSB first.
- R5: One cycle after the last checksum bit of a write frame, `ackValid` pulses for one cycle. `ackBit` is 1 if the checksum matched and 0 if it did not.
- R6: A matching write to a writable index (2 to 11 and 13) pulses `wrStrobe` in the same cycle as `ackValid`. In that cycle `wrIndex` holds the index and `wrLen` holds the field length. `wrData` holds the field right-aligned, with zeros above it.
- R7: A write to a read-only index (0, 1, 12, 15) or to the reserved index 14 is received and acknowledged in full, but it never pulses `wrStrobe`.
- R8: Bits that arrive without a preceding frame start produce no output.
- R9: After a frame completes, further bits are discarded until the next frame start.
- R10: A frame-start pulse in the middle of a frame is ignored, and reception of the current frame continues.
- R11: When `timeoutLimit` is non-zero, a frame that sees `timeoutLimit` consecutive cycles without a bit is dropped without an acknowledge. The parser then waits for a new frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | One-cycle pulse: a command was recognised |
| bitValid | input | 1 | `bitData` holds a received bit |
| bitData | input | 1 | Received bit value |
| timeoutLimit | input | TO_W | Idle cycles before a frame is dropped (0 disables the timeout) |
| wrStrobe | output | 1 | One-cycle register-write request |
| wrIndex | output | 4 | Index of the write |
| wrLen | output | 11 | Number of valid bits in `wrData` |
| wrData | output | WR_W | Write data, right-aligned |
| ackValid | output | 1 | One-cycle acknowledge pulse after a write frame |
| ackBit | output | 1 | Acknowledge value: 1 = checksum matched |
| readReq | output | 1 | One-cycle read-frame flag |
| readIndex | output | 4 | Index of the read |

## Verification
The assertions rely on two assumptions about the inputs. First, `timeoutLimit` stays constant while a frame is in progress. Second, `frameStart` and `bitValid` are never high in the same cycle while the parser is idle. The stimulus sets the timeout once, before the first frame, and always drops `frameStart` before it sends the first bit. The gaps between bits are kept at two cycles or fewer, which is well below the limit. Only the timeout test deliberately stalls a frame past the limit.

// File: rtl/cfg_frame_pkg.sv
package cfg_frame_pkg;

  localparam int IDX_W = 4;
  localparam int LEN_W = 11;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [LEN_W-1:0] len_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HDR,
    PH_DATA,
    PH_CK
  } phase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;     // new frame: wipe all accumulators
    logic takeHdr;   // shift a header bit
    logic takeData;  // shift a data bit
    logic takeCk;    // shift a checksum bit
    logic lastPay;   // this bit closes the summed part of the frame
  } dpCtrl_t;

  function automatic len_t fieldLen(idx_t idx);
    case (idx)
      4'd0:    return len_t'(8);
      4'd1:    return len_t'(24);
      4'd2:    return len_t'(8);
      4'd3:    return len_t'(18);
      4'd4:    return len_t'(8);
      4'd5:    return len_t'(124);
      4'd6:    return len_t'(124);
      4'd7:    return len_t'(42);
      4'd8:    return len_t'(56);
      4'd9:    return len_t'(160);
      4'd10:   return len_t'(46);
      4'd11:   return len_t'(8);
      4'd12:   return len_t'(1024);
      4'd13:   return len_t'(352);
      4'd15:   return len_t'(16);
      default: return len_t'(0);
    endcase
  endfunction

  function automatic logic isWritable(idx_t idx);
    case (idx)
      4'd0, 4'd1, 4'd12, 4'd14, 4'd15: return 1'b0;
      default:                         return 1'b1;
    endcase
  endfunction

  // eight-bit add with end-around carry
  function automatic logic [7:0] onesAdd(logic [7:0] a, logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'b0, s[8]};
  endfunction

endpackage

// File: rtl/cfg_frame_dp.sv
module cfg_frame_dp
  import cfg_frame_pkg::*;
#(
  parameter int WR_W = 352
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCtrl_t         ctrl,
  input  logic            bitIn,
  output logic [4:0]      nextHdr,
  output logic            ckMatch,
  output logic [WR_W-1:0] dataOut
);

  logic [3:0]      hdrReg;
  logic [6:0]      partByte;
  logic [2:0]      fill;
  logic [7:0]      sumAcc;
  logic [6:0]      ckReg;
  logic [WR_W-1:0] shiftReg;

  logic [7:0] nextPart;
  logic [3:0] nextFill;
  logic [7:0] aligned;
  logic       sumBit;
  logic       foldNow;

  assign nextHdr  = {hdrReg, bitIn};
  assign nextPart = {partByte, bitIn};
  assign nextFill = {1'b0, fill} + 4'd1;
  // a short final byte gets zeros appended at its low end
  assign aligned  = nextPart << (4'd8 - nextFill);
  assign sumBit   = ctrl.takeHdr | ctrl.takeData;
  assign foldNow  = sumBit & ((nextFill == 4'd8) | ctrl.lastPay);
  assign ckMatch  = ({ckReg, bitIn} == ~sumAcc);
  assign dataOut  = shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg   <= '0;
      partByte <= '0;
      fill     <= '0;
      sumAcc   <= '0;
      ckReg    <= '0;
      shiftReg <= '0;
    end else if (ctrl.clear) begin
      hdrReg   <= '0;
      partByte <= '0;
      fill     <= '0;
      sumAcc   <= '0;
      ckReg    <= '0;
      shiftReg <= '0;
    end else begin
      if (ctrl.takeHdr)  hdrReg   <= nextHdr[3:0];
      if (ctrl.takeData) shiftReg <= {shiftReg[WR_W-2:0], bitIn};
      if (ctrl.takeCk)   ckReg    <= {ckReg[5:0], bitIn};
      if (foldNow) begin
        sumAcc   <= onesAdd(sumAcc, aligned);
        partByte <= '0;
        fill     <= '0;
      end else if (sumBit) begin
        partByte <= nextPart[6:0];
        fill     <= nextFill[2:0];
      end
    end
  end

  // R4: the padded partial byte has been folded before any checksum bit
  a_r4_pad_flushed: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.takeCk |-> (fill == 3'd0 && partByte == 7'd0));

  // R4: the summing and checksum strobes never coincide
  a_r4_phase_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.takeCk && sumBit));

endmodule

// File: rtl/cfg_frame_ctrl.sv
module cfg_frame_ctrl
  import cfg_frame_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameStart,
  input  logic            bitValid,
  input  logic [4:0]      nextHdr,
  input  logic            ckMatch,
  input  logic [TO_W-1:0] timeoutLimit,
  output dpCtrl_t         ctrl,
  output logic            ackValid,
  output logic            ackBit,
  output logic            wrStrobe,
  output logic            readReq,
  output idx_t            curIdx,
  output len_t            dataLen
);

  phase_t          phase;
  len_t            bitCnt;
  logic [TO_W-1:0] idleCnt;
  len_t            hdrLen;
  logic            hdrLast;
  logic            dataLast;

  assign hdrLen   = fieldLen(nextHdr[3:0]);
  assign hdrLast  = (phase == PH_HDR) && (bitCnt == len_t'(4));
  assign dataLast = (phase == PH_DATA) && (bitCnt == dataLen - 1'b1);

  always_comb begin
    ctrl          = '0;
    ctrl.clear    = (phase == PH_IDLE) && frameStart;
    ctrl.takeHdr  = (phase == PH_HDR) && bitValid;
    ctrl.takeData = (phase == PH_DATA) && bitValid;
    ctrl.takeCk   = (phase == PH_CK) && bitValid;
    ctrl.lastPay  = bitValid && ((hdrLast && hdrLen == '0) || dataLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      idleCnt  <= '0;
      dataLen  <= '0;
      curIdx   <= '0;
      ackValid <= 1'b0;
      ackBit   <= 1'b0;
      wrStrobe <= 1'b0;
      readReq  <= 1'b0;
    end else begin
      ackValid <= 1'b0;
      ackBit   <= 1'b0;
      wrStrobe <= 1'b0;
      readReq  <= 1'b0;
      if (phase == PH_IDLE) begin
        if (frameStart) begin
          phase   <= PH_HDR;
          bitCnt  <= '0;
          idleCnt <= '0;
        end
      end else if (bitValid) begin
        idleCnt <= '0;
        case (phase)
          PH_HDR: begin
            if (hdrLast) begin
              curIdx <= nextHdr[3:0];
              bitCnt <= '0;
              if (!nextHdr[4]) begin
                readReq <= 1'b1;
                phase   <= PH_IDLE;
              end else begin
                dataLen <= hdrLen;
                phase   <= (hdrLen == '0) ? PH_CK : PH_DATA;
              end
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (dataLast) begin
              bitCnt <= '0;
              phase  <= PH_CK;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_CK: begin
            if (bitCnt == len_t'(7)) begin
              ackValid <= 1'b1;
              ackBit   <= ckMatch;
              wrStrobe <= ckMatch && isWritable(curIdx);
              phase    <= PH_IDLE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end else if (timeoutLimit != '0 && (idleCnt + 1'b1) >= timeoutLimit) begin
        phase <= PH_IDLE;
      end else begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  // R5: an acknowledge only ever closes the checksum phase
  a_r5_ack_after_ck: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(phase == PH_CK));

  // R6: a register write implies a passing acknowledge
  a_r6_strobe_on_pass: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (ackValid && ackBit));

  // R7: protected indices never reach the register port
  a_r7_no_protected_write: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> isWritable(curIdx));

  // R2: a read frame is never acknowledged
  a_r2_read_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    !(readReq && ackValid));

  // R8: without a frame start the parser stays idle
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && !frameStart) |=> (phase == PH_IDLE));

  // R11: the idle count never reaches the limit while a frame is open
  a_r11_timeout_bound: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && timeoutLimit != '0) |-> (idleCnt < timeoutLimit));

endmodule

// File: rtl/cfg_frame_parser.sv
module cfg_frame_parser
  import cfg_frame_pkg::*;
#(
  parameter int WR_W = 352,
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            frameStart,
  input  logic            bitValid,
  input  logic            bitData,
  input  logic [TO_W-1:0] timeoutLimit,
  output logic            wrStrobe,
  output logic [3:0]      wrIndex,
  output logic [10:0]     wrLen,
  output logic [WR_W-1:0] wrData,
  output logic            ackValid,
  output logic            ackBit,
  output logic            readReq,
  output logic [3:0]      readIndex
);

  dpCtrl_t    ctrl;
  logic [4:0] nextHdr;
  logic       ckMatch;
  idx_t       curIdx;
  len_t       dataLen;

  cfg_frame_ctrl #(.TO_W(TO_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameStart   (frameStart),
    .bitValid     (bitValid),
    .nextHdr      (nextHdr),
    .ckMatch      (ckMatch),
    .timeoutLimit (timeoutLimit),
    .ctrl         (ctrl),
    .ackValid     (ackValid),
    .ackBit       (ackBit),
    .wrStrobe     (wrStrobe),
    .readReq      (readReq),
    .curIdx       (curIdx),
    .dataLen      (dataLen)
  );

  cfg_frame_dp #(.WR_W(WR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .bitIn   (bitData),
    .nextHdr (nextHdr),
    .ckMatch (ckMatch),
    .dataOut (wrData)
  );

  assign wrIndex   = curIdx;
  assign readIndex = curIdx;
  assign wrLen     = dataLen;

endmodule

// File: tb/test_cfg_frame_parser.sv
module test_cfg_frame_parser;

  localparam int WR_W = 352;
  localparam int TO_W = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            frameStart = 1'b0;
  logic            bitValid = 1'b0;
  logic            bitData = 1'b0;
  logic [TO_W-1:0] timeoutLimit = 16'd20;
  logic            wrStrobe, ackValid, ackBit, readReq;
  logic [3:0]      wrIndex, readIndex;
  logic [10:0]     wrLen;
  logic [WR_W-1:0] wrData;

  cfg_frame_parser #(.WR_W(WR_W), .TO_W(TO_W)) i_cfg_frame_parser (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .bitValid(bitValid),
    .bitData(bitData), .timeoutLimit(timeoutLimit), .wrStrobe(wrStrobe),
    .wrIndex(wrIndex), .wrLen(wrLen), .wrData(wrData), .ackValid(ackValid),
    .ackBit(ackBit), .readReq(readReq), .readIndex(readIndex)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic            isRead;
    logic            ackB;
    logic            strobe;
    logic [3:0]      idx;
    logic [10:0]     len;
    logic [WR_W-1:0] data;
  } exp_t;

  exp_t  expQ[$];
  string reqQ[$];
  int    nChecks = 0;
  int    nFails = 0;
  int    nEvents = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  function automatic int refLen(logic [3:0] idx);
    case (idx)
      0: return 8;    1: return 24;  2: return 8;    3: return 18;
      4: return 8;    5: return 124; 6: return 124;  7: return 42;
      8: return 56;   9: return 160; 10: return 46;  11: return 8;
      12: return 1024; 13: return 352; 14: return 0; default: return 16;
    endcase
  endfunction

  function automatic bit refWritable(logic [3:0] idx);
    return !(idx == 0 || idx == 1 || idx == 12 || idx == 14 || idx == 15);
  endfunction

  function automatic logic [1023:0] mkPat(int seed);
    logic [1023:0] p;
    logic [31:0]   x;
    x = 32'(seed);
    for (int i = 0; i < 32; i++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      p[i*32 +: 32] = x;
    end
    return p;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [WR_W-1:0] act, input logic [WR_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  endtask

  // monitor: pops one expectation per observed event
  always @(negedge clk) begin
    if (rstN && (readReq || ackValid || wrStrobe)) begin
      exp_t  e;
      string r;
      nEvents++;
      if (expQ.size() == 0) begin
        nChecks++;
        nFails++;
        $display("FAIL %s unexpected output actual=ack%0b/wr%0b/rd%0b expected=none",
                 curReq, ackValid, wrStrobe, readReq);
      end else begin
        e = expQ.pop_front();
        r = reqQ.pop_front();
        if (e.isRead) begin
          chk(r, "readReq", readReq, 1);
          chk(r, "ackValid", ackValid, 0);
          chk(r, "readIndex", readIndex, e.idx);
        end else begin
          chk(r, "ackValid", ackValid, 1);
          chk(r, "ackBit", ackBit, e.ackB);
          chk(r, "wrStrobe", wrStrobe, e.strobe);
          if (e.strobe) begin
            chk(r, "wrIndex", wrIndex, e.idx);
            chk(r, "wrLen", wrLen, e.len);
            chk(r, "wrData", wrData, e.data);
          end
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    bitValid = 1'b1;
    bitData  = b;
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic pulseStart();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  // driver: predicts the outcome, queues it, then sends the frame
  task automatic sendFrame(input bit rw, input logic [3:0] idx,
                           input logic [1023:0] d, input bit badCk,
                           input int intAt, input string req);
    int          len;
    int          cur;
    int          cnt;
    int          sum;
    int          k;
    logic [4:0]  hdr;
    logic [7:0]  ck;
    exp_t        e;
    curReq = req;
    len = rw ? refLen(idx) : 0;
    hdr = {rw, idx};
    cur = 0; cnt = 0; sum = 0;
    for (int i = 0; i < 5 + len; i++) begin
      bit b;
      b = (i < 5) ? hdr[4-i] : d[len-1-(i-5)];
      cur = (cur << 1) | int'(b);
      cnt++;
      if (cnt == 8) begin sum += cur; cur = 0; cnt = 0; end
    end
    if (cnt > 0) sum += (cur << (8 - cnt)) & 255;
    while (sum > 255) sum = (sum & 255) + (sum >> 8);
    ck = ~8'(sum);
    e = '0;
    e.isRead = !rw;
    e.idx    = idx;
    e.ackB   = !badCk;
    e.strobe = rw && !badCk && refWritable(idx);
    e.len    = 11'(len);
    for (int i = 0; i < WR_W; i++) e.data[i] = (i < len) ? d[i] : 1'b0;
    expQ.push_back(e);
    reqQ.push_back(req);
    pulseStart();
    k = 0;
    for (int i = 0; i < 5; i++) begin
      if (k == intAt) pulseStart();
      sendBit(hdr[4-i]); idle(k % 3); k++;
    end
    if (rw) begin
      for (int i = len - 1; i >= 0; i--) begin
        if (k == intAt) pulseStart();
        sendBit(d[i]); idle(k % 3); k++;
      end
      if (badCk) ck = ck ^ 8'h5A;
      for (int i = 7; i >= 0; i--) begin
        if (k == intAt) pulseStart();
        sendBit(ck[i]); idle(k % 2); k++;
      end
    end
    idle(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL %s watchdog expired actual=running expected=finished", curReq);
    finishRun();
  end

  initial begin
    int evBefore;
    idle(3);
    // R1: quiet outputs out of reset
    chk("R1", "ackValid in reset", ackValid, 0);
    rstN = 1'b1;
    idle(2);
    chk("R1", "ackValid", ackValid, 0);
    chk("R1", "wrStrobe", wrStrobe, 0);
    chk("R1", "readReq", readReq, 0);

    // R6 and R3: writable indices, various lengths; R4 padding in each
    sendFrame(1, 4'd2, mkPat(1), 0, -1, "R6");
    sendFrame(1, 4'd7, mkPat(2), 0, -1, "R3");
    sendFrame(1, 4'd10, mkPat(3), 0, -1, "R4");
    sendFrame(1, 4'd13, mkPat(4), 0, -1, "R6");
    sendFrame(1, 4'd3, mkPat(5), 0, -1, "R4");
    sendFrame(1, 4'd9, mkPat(6), 0, -1, "R3");

    // R5: corrupted checksum gives a negative acknowledge
    sendFrame(1, 4'd3, mkPat(7), 1, -1, "R5");
    sendFrame(1, 4'd8, mkPat(8), 1, -1, "R5");

    // R7: protected indices acknowledged without a write
    sendFrame(1, 4'd0, mkPat(9), 0, -1, "R7");
    sendFrame(1, 4'd15, mkPat(10), 0, -1, "R7");
    sendFrame(1, 4'd14, mkPat(11), 0, -1, "R7");
    sendFrame(1, 4'd12, mkPat(12), 0, -1, "R7");

    // R2: read frames are only flagged
    sendFrame(0, 4'd9, mkPat(13), 0, -1, "R2");
    sendFrame(0, 4'd12, mkPat(14), 0, -1, "R2");

    // R8: bits with no frame start
    curReq = "R8";
    evBefore = nEvents;
    for (int i = 0; i < 40; i++) sendBit(1'(i % 3 == 0));
    idle(4);
    chk("R8", "events from stray bits", nEvents - evBefore, 0);
    sendFrame(1, 4'd4, mkPat(15), 0, -1, "R8");

    // R9: surplus bits after a complete frame
    sendFrame(1, 4'd11, mkPat(16), 0, -1, "R9");
    curReq = "R9";
    evBefore = nEvents;
    for (int i = 0; i < 30; i++) sendBit(1'b1);
    idle(4);
    chk("R9", "events from surplus bits", nEvents - evBefore, 0);
    sendFrame(1, 4'd5, mkPat(17), 0, -1, "R9");

    // R10: start pulses in the middle of a frame
    sendFrame(1, 4'd7, mkPat(18), 0, 3, "R10");
    sendFrame(1, 4'd2, mkPat(19), 0, 9, "R10");

    // R11: stalled partial frame is dropped
    curReq = "R11";
    evBefore = nEvents;
    pulseStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    idle(30);
    chk("R11", "events from stalled frame", nEvents - evBefore, 0);
    sendFrame(1, 4'd6, mkPat(20), 0, -1, "R11");

    idle(10);
    chk("R5", "expectations left over", expQ.size(), 0);
    finishRun();
  end

endmodule